// File: doc/BRIEF.md
# Transmit Descriptor Ring Completion Engine

This block runs one transmit descriptor ring kept in a small on-chip descriptor memory. Software fills 128-bit descriptors, each holding a buffer address, a length, frame markers and a flag field. It then moves a head index forward to hand them over. The engine owns a tail index. For every descriptor between tail and head it reads the entry and offers a transfer request to a data mover. It then waits for a one-cycle done pulse. After that it writes the descriptor back with its completion mark set, steps the tail, and can pulse a completion event.

The request channel toward the data mover is valid/ready. Once `req_valid` is high, the engine holds it and all request fields steady until a cycle in which `req_ready` is also high. The mover may hold `req_ready` low for any number of cycles to apply back-pressure. The `done` pulse is only honoured after the request has been accepted. A pulse at any other time is ignored. The register port, the memory port and the event output are plain control pins.

Descriptor layout (bit positions within the 128-bit word): [63:0] buffer address, [75:64] length, [79:76] end-of-frame marker, [83:80] start-of-frame marker, [95:84] flags, [127:96] time word (written as zero). The flag bits are: bit 0 isochronous, bit 1 completion mark (set by the engine), bit 2 posted, bit 3 interrupt request. The register addresses are: 0 memory base of the ring, 1 head, 2 tail (read only), 3 descriptor count, 4 option word. In the option word, bit 31 is enable, bit 30 is raw, bit 29 is no-snoop, bit 28 is end-to-end flow control and bit 27 is isochronous enable.

Top module: `tx_ring_engine`

## Requirements
- R1: After reset all registers read zero, and `req_valid`, `cmpl_evt`, `mem_rd_en` and `mem_wr_en` are low.
- R2: A request carries the address, length, end-of-frame and start-of-frame fields of the descriptor at memory word `base + tail`.
- R3: While `req_valid` is high and `req_ready` is low, `req_valid` stays high and every request field stays unchanged.
- R4: After the `done` pulse the engine writes the descriptor back to the same memory word with flag bit 1 (word bit 85) set and all other bits unchanged.
- R5: Each completion advances the tail by one, and the tail wraps to zero when it reaches the descriptor count.
- R6: `cmpl_evt` pulses for exactly one cycle per completed descriptor, and only when its flag bit 3 (word bit 87) is set.
- R7: When tail equals head, no descriptor is read and no request is made. Processing resumes once head is moved.
- R8: A descriptor whose flag bit 2 (word bit 86) is clear is not requested, and the tail stays at it. The engine re-reads it until the bit is found set.
- R9: Clearing option bit 31 lets a descriptor already being fetched or transferred complete normally. No further descriptor is read, and the tail resets to zero.
- R10: With option bit 30 (raw) set, the request end-of-frame and start-of-frame fields are driven as zero.
- R11: A register write to the tail address (2) has no effect on the tail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational on cfg_addr) |
| mem_rd_en | output | 1 | Descriptor memory read strobe; data expected one cycle later |
| mem_wr_en | output | 1 | Descriptor memory write strobe |
| mem_addr | output | MEM_AW | Descriptor memory word address |
| mem_rdata | input | 128 | Descriptor memory read data |
| mem_wdata | output | 128 | Descriptor memory write data |
| req_valid | output | 1 | Transfer request valid |
| req_ready | input | 1 | Data mover accepts the request |
| req_addr | output | 64 | Buffer address of the request |
| req_len | output | 12 | Byte length of the request |
| req_eof | output | 4 | End-of-frame marker |
| req_sof | output | 4 | Start-of-frame marker |
| done | input | 1 | One-cycle transfer finished pulse |
| cmpl_evt | output | 1 | One-cycle completion event |

## Verification
A table of six descriptors is pushed through a four-entry ring. The entries differ in length, markers, interrupt request, raw mode and back-pressure delay. This separates field routing from the descriptor into the request, the wrap of the tail, and event gating by the request bit. Directed patterns cover an empty ring, a descriptor left unposted and posted later, and enable dropped while a request is pending. A write to the tail address is also tried. Each of these shows whether the engine fetches when it must not and stalls where it should.

// File: rtl/txr_pkg.sv
package txr_pkg;

  // 128-bit descriptor word; first member is the most significant.
  typedef struct packed {
    logic [31:0] stamp;
    logic [11:0] flags;
    logic [3:0]  sof;
    logic [3:0]  eof;
    logic [11:0] len;
    logic [63:0] addr;
  } txr_desc_t;

  localparam int FLG_ISOCH  = 0;
  localparam int FLG_DONE   = 1;
  localparam int FLG_POSTED = 2;
  localparam int FLG_IRQ    = 3;

  localparam int OPT_EN     = 31;
  localparam int OPT_RAW    = 30;

  localparam logic [2:0] RA_BASE  = 3'd0;
  localparam logic [2:0] RA_HEAD  = 3'd1;
  localparam logic [2:0] RA_TAIL  = 3'd2;
  localparam logic [2:0] RA_COUNT = 3'd3;
  localparam logic [2:0] RA_OPTS  = 3'd4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_OFFER,
    ST_BUSY,
    ST_WBACK
  } txr_state_t;

endpackage

// File: rtl/txr_regs.sv
module txr_regs
  import txr_pkg::*;
#(
  parameter int IDX_W  = 4,
  parameter int MEM_AW = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic [IDX_W-1:0]  tail_i,
  output logic [MEM_AW-1:0] base_o,
  output logic [IDX_W-1:0]  head_o,
  output logic [IDX_W:0]    count_o,
  output logic              enable_o,
  output logic              raw_o
);

  logic [MEM_AW-1:0] base_q;
  logic [IDX_W-1:0]  head_q;
  logic [IDX_W:0]    count_q;
  logic [31:0]       opts_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q  <= '0;
      head_q  <= '0;
      count_q <= '0;
      opts_q  <= '0;
    end else if (cfg_we) begin
      case (cfg_addr)
        RA_BASE:  base_q  <= cfg_wdata[MEM_AW-1:0];
        RA_HEAD:  head_q  <= cfg_wdata[IDX_W-1:0];
        RA_COUNT: count_q <= cfg_wdata[IDX_W:0];
        RA_OPTS:  opts_q  <= cfg_wdata;
        default:  ;
      endcase
    end
  end

  always_comb begin
    case (cfg_addr)
      RA_BASE:  cfg_rdata = {{(32-MEM_AW){1'b0}}, base_q};
      RA_HEAD:  cfg_rdata = {{(32-IDX_W){1'b0}}, head_q};
      RA_TAIL:  cfg_rdata = {{(32-IDX_W){1'b0}}, tail_i};
      RA_COUNT: cfg_rdata = {{(31-IDX_W){1'b0}}, count_q};
      RA_OPTS:  cfg_rdata = opts_q;
      default:  cfg_rdata = '0;
    endcase
  end

  assign base_o   = base_q;
  assign head_o   = head_q;
  assign count_o  = count_q;
  assign enable_o = opts_q[OPT_EN];
  assign raw_o    = opts_q[OPT_RAW];

endmodule

// File: rtl/txr_idx_step.sv
module txr_idx_step #(
  parameter int IDX_W = 4
) (
  input  logic [IDX_W-1:0] cur_i,
  input  logic [IDX_W:0]   count_i,
  output logic [IDX_W-1:0] nxt_o
);

  logic [IDX_W:0] inc;

  always_comb begin
    inc   = {1'b0, cur_i} + 1'b1;
    nxt_o = (inc >= count_i) ? '0 : inc[IDX_W-1:0];
  end

endmodule

// File: rtl/txr_walker.sv
module txr_walker
  import txr_pkg::*;
#(
  parameter int IDX_W  = 4,
  parameter int MEM_AW = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable_i,
  input  logic              raw_i,
  input  logic [MEM_AW-1:0] base_i,
  input  logic [IDX_W-1:0]  head_i,
  input  logic [IDX_W:0]    count_i,
  output logic              mem_rd_en,
  output logic              mem_wr_en,
  output logic [MEM_AW-1:0] mem_addr,
  input  txr_desc_t         mem_rdata,
  output txr_desc_t         mem_wdata,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [63:0]       req_addr,
  output logic [11:0]       req_len,
  output logic [3:0]        req_eof,
  output logic [3:0]        req_sof,
  input  logic              done,
  output logic              cmpl_evt,
  output logic [IDX_W-1:0]  tail_o
);

  txr_state_t       state_q;
  logic [IDX_W-1:0] tail_q;
  logic [IDX_W-1:0] tail_nxt;
  txr_desc_t        desc_q;

  txr_idx_step #(.IDX_W(IDX_W)) u_step (
    .cur_i   (tail_q),
    .count_i (count_i),
    .nxt_o   (tail_nxt)
  );

  always_comb begin
    mem_rd_en = (state_q == ST_IDLE) && enable_i && (tail_q != head_i);
    mem_wr_en = (state_q == ST_WBACK);
    mem_addr  = base_i + MEM_AW'(tail_q);
    mem_wdata = desc_q;
    mem_wdata.flags[FLG_DONE] = 1'b1;
    req_valid = (state_q == ST_OFFER);
    req_addr  = desc_q.addr;
    req_len   = desc_q.len;
    req_eof   = raw_i ? 4'd0 : desc_q.eof;
    req_sof   = raw_i ? 4'd0 : desc_q.sof;
    cmpl_evt  = (state_q == ST_WBACK) && desc_q.flags[FLG_IRQ];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      tail_q  <= '0;
      desc_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (!enable_i)      tail_q  <= '0;
          else if (mem_rd_en) state_q <= ST_FETCH;
        end
        ST_FETCH: begin
          desc_q  <= mem_rdata;
          state_q <= mem_rdata.flags[FLG_POSTED] ? ST_OFFER : ST_IDLE;
        end
        ST_OFFER: if (req_ready) state_q <= ST_BUSY;
        ST_BUSY:  if (done)      state_q <= ST_WBACK;
        ST_WBACK: begin
          tail_q  <= tail_nxt;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign tail_o = tail_q;

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) &&
      $stable(req_len) && $stable(req_eof) && $stable(req_sof)));

  // R4
  wback_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> $past(done));

  // R5
  tail_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tail_q) |-> ((tail_q == '0) || (tail_q == IDX_W'($past(tail_q) + 1'b1))));

  // R6
  evt_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmpl_evt |=> !cmpl_evt);

  // R8
  posted_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid) |-> $past(mem_rdata.flags[FLG_POSTED]));

  // R7
  fetch_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid) |-> $past(mem_rd_en, 2));

endmodule

// File: rtl/tx_ring_engine.sv
module tx_ring_engine
  import txr_pkg::*;
#(
  parameter int IDX_W  = 4,
  parameter int MEM_AW = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  output logic              mem_rd_en,
  output logic              mem_wr_en,
  output logic [MEM_AW-1:0] mem_addr,
  input  logic [127:0]      mem_rdata,
  output logic [127:0]      mem_wdata,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [63:0]       req_addr,
  output logic [11:0]       req_len,
  output logic [3:0]        req_eof,
  output logic [3:0]        req_sof,
  input  logic              done,
  output logic              cmpl_evt
);

  logic [MEM_AW-1:0] base_w;
  logic [IDX_W-1:0]  head_w;
  logic [IDX_W-1:0]  tail_w;
  logic [IDX_W:0]    count_w;
  logic              enable_w;
  logic              raw_w;
  txr_desc_t         rd_desc;
  txr_desc_t         wr_desc;

  assign rd_desc   = txr_desc_t'(mem_rdata);
  assign mem_wdata = 128'(wr_desc);

  txr_regs #(.IDX_W(IDX_W), .MEM_AW(MEM_AW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .tail_i    (tail_w),
    .base_o    (base_w),
    .head_o    (head_w),
    .count_o   (count_w),
    .enable_o  (enable_w),
    .raw_o     (raw_w)
  );

  txr_walker #(.IDX_W(IDX_W), .MEM_AW(MEM_AW)) u_walker (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable_i  (enable_w),
    .raw_i     (raw_w),
    .base_i    (base_w),
    .head_i    (head_w),
    .count_i   (count_w),
    .mem_rd_en (mem_rd_en),
    .mem_wr_en (mem_wr_en),
    .mem_addr  (mem_addr),
    .mem_rdata (rd_desc),
    .mem_wdata (wr_desc),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .req_len   (req_len),
    .req_eof   (req_eof),
    .req_sof   (req_sof),
    .done      (done),
    .cmpl_evt  (cmpl_evt),
    .tail_o    (tail_w)
  );

  // R9
  no_fetch_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> $past(rst_n) && (cfg_rdata == cfg_rdata) && enable_w);

endmodule

// File: tb/test_tx_ring_engine.sv
module test_tx_ring_engine;

  localparam int IDX_W  = 4;
  localparam int MEM_AW = 6;
  localparam int BASE   = 8;
  localparam int CNT    = 4;

  typedef struct packed {
    logic [63:0] addr;
    logic [11:0] len;
    logic [3:0]  eof;
    logic [3:0]  sof;
    logic        irq;
    logic        raw;
    logic [2:0]  stall;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{64'h0000_0001_0000_0040, 12'd64,   4'h1, 4'h2, 1'b1, 1'b0, 3'd0},
    '{64'h0000_0000_8000_1000, 12'd4095, 4'hF, 4'h0, 1'b0, 1'b0, 3'd3},
    '{64'hDEAD_BEEF_0000_0100, 12'd1,    4'h5, 4'hA, 1'b1, 1'b1, 3'd1},
    '{64'h0000_0000_0000_0000, 12'd256,  4'h3, 4'hC, 1'b0, 1'b0, 3'd5},
    '{64'hFFFF_FFFF_FFFF_FFF0, 12'd2048, 4'h8, 4'h7, 1'b1, 1'b0, 3'd2},
    '{64'h1234_5678_9ABC_DEF0, 12'd12,   4'h6, 4'h9, 1'b1, 1'b1, 3'd0}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cfg_we = 1'b0;
  logic [2:0]        cfg_addr = '0;
  logic [31:0]       cfg_wdata = '0;
  logic [31:0]       cfg_rdata;
  logic              mem_rd_en, mem_wr_en;
  logic [MEM_AW-1:0] mem_addr;
  logic [127:0]      mem_rdata = '0;
  logic [127:0]      mem_wdata;
  logic              req_valid;
  logic              req_ready = 1'b0;
  logic [63:0]       req_addr;
  logic [11:0]       req_len;
  logic [3:0]        req_eof, req_sof;
  logic              done = 1'b0;
  logic              cmpl_evt;

  logic [127:0] dmem [64];
  int checks = 0;
  int fails = 0;
  int evt_cnt = 0;
  int rd_cnt = 0;
  int val_cnt = 0;

  always #4 clk = ~clk;

  tx_ring_engine #(.IDX_W(IDX_W), .MEM_AW(MEM_AW)) i_tx_ring_engine (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .mem_rd_en(mem_rd_en),
    .mem_wr_en(mem_wr_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .mem_wdata(mem_wdata), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .req_eof(req_eof),
    .req_sof(req_sof), .done(done), .cmpl_evt(cmpl_evt)
  );

  always @(posedge clk) begin
    if (mem_rd_en) mem_rdata <= dmem[mem_addr];
    if (mem_wr_en) dmem[mem_addr] <= mem_wdata;
    if (rst_n && cmpl_evt)  evt_cnt <= evt_cnt + 1;
    if (rst_n && mem_rd_en) rd_cnt  <= rd_cnt + 1;
    if (rst_n && req_valid) val_cnt <= val_cnt + 1;
  end

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  function automatic logic [127:0] mk(input logic [63:0] a, input logic [11:0] l,
      input logic [3:0] e, input logic [3:0] s, input logic [11:0] f);
    return {32'd0, f, s, e, l, a};
  endfunction

  // waits for a request, holds ready low for stall cycles while checking fields,
  // accepts it, then pulses done
  task automatic serve(input string tag, input int stall, input logic [63:0] ea,
      input logic [11:0] el, input logic [3:0] ee, input logic [3:0] es);
    int w = 0;
    @(negedge clk);
    while (!req_valid && w < 60) begin
      @(negedge clk);
      w++;
    end
    chk({tag, " R2 request seen"}, 128'(req_valid), 128'd1);
    chk({tag, " R2 fields"}, {req_addr, req_len, req_eof, req_sof}, {ea, el, ee, es});
    for (int k = 0; k < stall; k++) begin
      @(negedge clk);
      chk({tag, " R3 hold under back-pressure"},
          {req_valid, req_addr, req_len, req_eof, req_sof}, {1'b1, ea, el, ee, es});
    end
    req_ready = 1'b1;
    @(negedge clk);
    req_ready = 1'b0;
    repeat (2) @(negedge clk);
    done = 1'b1;
    @(negedge clk);
    done = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    int idx = 0;
    int ev0;
    int rd0;
    int v0;
    logic [127:0] d;
    for (int i = 0; i < 64; i++) dmem[i] = '0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), r);
      chk("R1 register reset", 128'(r), 128'd0);
    end
    chk("R1 outputs idle", {req_valid, cmpl_evt, mem_rd_en, mem_wr_en}, 4'b0);

    wr(3'd0, BASE);
    wr(3'd3, CNT);
    wr(3'd4, 32'h8000_0000);

    // table walk
    for (int i = 0; i < 6; i++) begin
      logic [11:0] fl;
      fl = {8'd0, VEC[i].irq, 1'b1, 1'b0, 1'b0};
      d = mk(VEC[i].addr, VEC[i].len, VEC[i].eof, VEC[i].sof, fl);
      dmem[BASE + idx] = d;
      wr(3'd4, {1'b1, VEC[i].raw, 30'd0});
      ev0 = evt_cnt;
      wr(3'd1, 32'((idx + 1) % CNT));
      serve($sformatf("vec%0d", i), int'(VEC[i].stall), VEC[i].addr, VEC[i].len,
            VEC[i].raw ? 4'd0 : VEC[i].eof, VEC[i].raw ? 4'd0 : VEC[i].sof);
      chk("R10 raw markers / R4 writeback done bit", dmem[BASE + idx], d | (128'd1 << 85));
      rd(3'd2, r);
      chk("R5 tail advance and wrap", 128'(r), 128'((idx + 1) % CNT));
      chk("R6 event only on request bit", 128'(evt_cnt - ev0), 128'(VEC[i].irq));
      idx = (idx + 1) % CNT;
    end
    wr(3'd4, 32'h8000_0000);

    // R7 empty ring stalls, then resumes
    rd0 = rd_cnt; v0 = val_cnt;
    repeat (20) @(negedge clk);
    chk("R7 no fetch when empty", 128'(rd_cnt - rd0), 128'd0);
    chk("R7 no request when empty", 128'(val_cnt - v0), 128'd0);
    d = mk(64'hAB, 12'd9, 4'h2, 4'h4, 12'h004);
    dmem[BASE + idx] = d;
    wr(3'd1, 32'((idx + 1) % CNT));
    serve("R7 resume", 0, 64'hAB, 12'd9, 4'h2, 4'h4);
    rd(3'd2, r);
    chk("R7 resumed tail", 128'(r), 128'((idx + 1) % CNT));
    idx = (idx + 1) % CNT;

    // R8 unposted descriptor is a stop point
    d = mk(64'hCD, 12'd33, 4'h1, 4'h1, 12'h008);
    dmem[BASE + idx] = d;
    v0 = val_cnt;
    wr(3'd1, 32'((idx + 1) % CNT));
    repeat (20) @(negedge clk);
    chk("R8 unposted not requested", 128'(val_cnt - v0), 128'd0);
    rd(3'd2, r);
    chk("R8 tail held at unposted", 128'(r), 128'(idx));
    ev0 = evt_cnt;
    dmem[BASE + idx] = d | (128'd1 << 86);
    serve("R8 posted later", 0, 64'hCD, 12'd33, 4'h1, 4'h1);
    chk("R8 completes after posting", dmem[BASE + idx], d | (128'd1 << 86) | (128'd1 << 85));
    chk("R6 event after posting", 128'(evt_cnt - ev0), 128'd1);
    idx = (idx + 1) % CNT;

    // R9 disable while a request is pending
    d = mk(64'hEF, 12'd7, 4'h0, 4'h0, 12'h004);
    dmem[BASE + idx] = d;
    dmem[BASE + ((idx + 1) % CNT)] = d;
    wr(3'd1, 32'((idx + 2) % CNT));
    begin
      int w = 0;
      while (!req_valid && w < 60) begin
        @(negedge clk);
        w++;
      end
    end
    wr(3'd4, 32'h0000_0000);
    serve("R9 in-flight", 0, 64'hEF, 12'd7, 4'h0, 4'h0);
    chk("R9 in-flight writeback", dmem[BASE + idx], d | (128'd1 << 85));
    rd(3'd2, r);
    chk("R9 tail reset on disable", 128'(r), 128'd0);
    rd0 = rd_cnt;
    repeat (20) @(negedge clk);
    chk("R9 no fetch while disabled", 128'(rd_cnt - rd0), 128'd0);

    // R11 tail is read only
    wr(3'd2, 32'd3);
    rd(3'd2, r);
    chk("R11 tail write ignored", 128'(r), 128'd0);

    finish_run();
  end

endmodule